// File: doc/BRIEF.md
# Decode-Group Instruction Pair Fuser

This block sits after the decoders of a multi-slot decode group. It takes one 32-bit RISC-V instruction per slot and looks at every neighbouring pair. It searches for short shift, and, add and or sequences that do the work of a single operation. When a pair fits one of these sequences, the older slot becomes one internal micro-op that carries a fusion opcode. The younger slot is dropped from the group. The block is purely combinational, so one decode group is rewritten in the cycle it arrives.

For each slot the block reports:
- whether the slot is still valid;
- whether the slot now carries a fused micro-op, and its fusion opcode;
- the destination and the two source registers to use;
- a 2-bit length tag, which the commit logic uses to account for the dropped instruction's address.

Each slot also has an input flag that says whether it came from a 16-bit compressed instruction. The two flags of a fused pair form the length tag. Expanding compressed instructions and executing the new micro-ops are done elsewhere.

Top module: `pair_fuser`

## Requirements
- R1: An output slot is valid exactly when its input slot is valid and it has not been taken as the younger half of a fusion. With all inputs invalid, no output is valid and none is fused.
- R2: Pairs are resolved from slot 0 upward.
  - A slot taken as a younger half cannot start a fusion of its own.
  - The last slot never starts a fusion.
  - A fusion needs both slots of the pair to be valid.
- R3: `slli d,s,N` with N from 1 to 4, followed by `add d` that uses d, gives opcode N.
- R4: `slli d,s,32` followed by `srli d,d,K` gives opcode 5 for K=31, opcode 6 for K=30 and opcode 7 for K=29.
- R5: `srli d,s,K` with K from 29 to 32, followed by `add d` that uses d, gives opcode 8+(K-29).
- R6: `srli d,s,8` followed by `andi d,d,255` gives opcode 12.
- R7: `andi d,s,1` followed by `add d` that uses d gives opcode 13. Followed by `addw d` that uses d, it gives opcode 14.
- R8: `andi d,s,-256` followed by `or d` that uses d gives opcode 15.
- R9: Conditions for a fusion:
  - Both instructions write the same d, and d is not x0.
  - When the second instruction is `srli` or `andi`, it reads d in rs1.
  - When the second instruction is `add`, `addw` or `or`, exactly one of its sources is d.
  - Shift amounts and immediates must match exactly, and the upper six immediate bits of a shift must be zero.
  - Otherwise there is no fusion.
- R10: A fused slot reports:
  - rd = d;
  - rs1 = the first instruction's rs1;
  - rs2 = the second instruction's source that is not d, or 0 when the second instruction has a single source.

  A slot that is not fused reports its own fields: rd at bits 11:7, rs1 at bits 19:15, rs2 at bits 24:20.
- R11: A fused slot's tag is {first slot compressed, second slot compressed}. A slot that is not fused has tag 0.
- R12: A slot that is not fused reports fused=0 and opcode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_valid | input | SLOTS | per-slot instruction valid |
| in_instr | input | 32*SLOTS | slot i at bits [32i+31:32i] |
| in_rvc | input | SLOTS | slot came from a 16-bit instruction |
| out_valid | output | SLOTS | slot valid after fusion |
| out_fused | output | SLOTS | slot carries a fused micro-op |
| out_op | output | 4*SLOTS | fusion opcode per slot |
| out_rd | output | 5*SLOTS | destination register per slot |
| out_rs1 | output | 5*SLOTS | first source register per slot |
| out_rs2 | output | 5*SLOTS | second source register per slot |
| out_tag | output | 2*SLOTS | length tag of a fused pair |

## Verification
The block holds no state, so any wrong pairing decision shows at the ports in the same cycle as the group that causes it. A wrong priority or consumed-slot decision shows in one of three ways:
- a younger slot that stays valid;
- two neighbouring fused slots;
- a fusion that lands one slot too late.

The bench therefore compares every slot of every group against a behavioural model in the cycle the group is applied. Its random groups draw registers from a small pool and shift amounts next to the legal ones, so that near-miss pairs are frequent.

// File: rtl/pair_fuser.sv
module pair_fuser #(
  parameter int SLOTS = 4
) (
  input  logic [SLOTS-1:0]    in_valid,
  input  logic [32*SLOTS-1:0] in_instr,
  input  logic [SLOTS-1:0]    in_rvc,
  output logic [SLOTS-1:0]    out_valid,
  output logic [SLOTS-1:0]    out_fused,
  output logic [4*SLOTS-1:0]  out_op,
  output logic [5*SLOTS-1:0]  out_rd,
  output logic [5*SLOTS-1:0]  out_rs1,
  output logic [5*SLOTS-1:0]  out_rs2,
  output logic [2*SLOTS-1:0]  out_tag
);
  localparam logic [6:0] OPC_IMM = 7'b0010011;
  localparam logic [6:0] OPC_REG = 7'b0110011;
  localparam logic [6:0] OPC_R32 = 7'b0111011;

  function automatic logic [8:0] match_pair(input logic [31:0] a, input logic [31:0] b);
    logic [4:0] d, oth;
    logic [3:0] op;
    logic [5:0] ash, bsh;
    logic a_slli, a_srli, a_andi, b_srli, b_andi, b_add, b_addw, b_or, one_src;
    d       = a[11:7];
    ash     = a[25:20];
    bsh     = b[25:20];
    a_slli  = a[6:0] == OPC_IMM && a[14:12] == 3'b001 && a[31:26] == 6'd0;
    a_srli  = a[6:0] == OPC_IMM && a[14:12] == 3'b101 && a[31:26] == 6'd0;
    a_andi  = a[6:0] == OPC_IMM && a[14:12] == 3'b111;
    b_srli  = b[6:0] == OPC_IMM && b[14:12] == 3'b101 && b[31:26] == 6'd0 && b[19:15] == d;
    b_andi  = b[6:0] == OPC_IMM && b[14:12] == 3'b111 && b[19:15] == d;
    b_add   = b[6:0] == OPC_REG && b[14:12] == 3'b000 && b[31:25] == 7'd0;
    b_or    = b[6:0] == OPC_REG && b[14:12] == 3'b110 && b[31:25] == 7'd0;
    b_addw  = b[6:0] == OPC_R32 && b[14:12] == 3'b000 && b[31:25] == 7'd0;
    one_src = (b[19:15] == d) != (b[24:20] == d);
    oth     = (b[19:15] == d) ? b[24:20] : b[19:15];
    op      = 4'd0;
    if (d != 5'd0 && b[11:7] == d) begin
      if (a_slli && ash >= 6'd1 && ash <= 6'd4 && b_add && one_src)
        op = ash[3:0];
      else if (a_slli && ash == 6'd32 && b_srli && bsh >= 6'd29 && bsh <= 6'd31)
        op = 4'(6'd36 - bsh);
      else if (a_srli && ash >= 6'd29 && ash <= 6'd32 && b_add && one_src)
        op = 4'(ash - 6'd21);
      else if (a_srli && ash == 6'd8 && b_andi && b[31:20] == 12'h0FF)
        op = 4'd12;
      else if (a_andi && a[31:20] == 12'h001 && (b_add || b_addw) && one_src)
        op = b_addw ? 4'd14 : 4'd13;
      else if (a_andi && a[31:20] == 12'hF00 && b_or && one_src)
        op = 4'd15;
    end
    if (op == 4'd0 || (op >= 4'd5 && op <= 4'd7) || op == 4'd12) oth = 5'd0;
    return {op, oth};
  endfunction

  logic [32*(SLOTS+1)-1:0] ins_x;
  logic [SLOTS:0]          val_x, rvc_x;
  assign ins_x = {32'd0, in_instr};
  assign val_x = {1'b0, in_valid};
  assign rvc_x = {1'b0, in_rvc};

  always_comb begin
    logic taken;
    logic go;
    logic [8:0] pr;
    logic [31:0] cur;
    taken = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      cur = ins_x[32*i +: 32];
      pr  = match_pair(cur, ins_x[32*(i+1) +: 32]);
      go  = !taken && val_x[i] && val_x[i+1] && pr[8:5] != 4'd0;
      out_valid[i]      = val_x[i] && !taken;
      out_fused[i]      = go;
      out_op[4*i +: 4]  = go ? pr[8:5] : 4'd0;
      out_rd[5*i +: 5]  = cur[11:7];
      out_rs1[5*i +: 5] = cur[19:15];
      out_rs2[5*i +: 5] = go ? pr[4:0] : cur[24:20];
      out_tag[2*i +: 2] = go ? {rvc_x[i], rvc_x[i+1]} : 2'b00;
      taken = go;
    end
  end

  always_comb begin
    AST_LAST_NO_START: assert (!out_fused[SLOTS-1]); // R2
    for (int i = 0; i < SLOTS; i++) begin
      AST_DEST_NONZERO: assert (!out_fused[i] || out_rd[5*i +: 5] != 5'd0); // R9
      AST_IDLE_ZERO: assert (out_fused[i] || (out_op[4*i +: 4] == 4'd0 && out_tag[2*i +: 2] == 2'd0)); // R12
      AST_FUSED_VALID: assert (!out_fused[i] || out_valid[i]); // R1
    end
    for (int i = 0; i < SLOTS-1; i++) begin
      AST_NO_CHAIN: assert (!(out_fused[i] && out_fused[i+1])); // R2
      AST_YOUNG_KILLED: assert (!out_fused[i] || (in_valid[i+1] && !out_valid[i+1])); // R1
    end
  end
endmodule

// File: tb/pair_fuser_tb.sv
`timescale 1ns/1ps
module pair_fuser_tb;
  localparam int S = 4;
  logic clk = 0;
  logic rst = 1;
  always #4 clk = ~clk;

  logic [S-1:0] in_valid, in_rvc;
  logic [32*S-1:0] in_instr;
  logic [S-1:0] out_valid, out_fused;
  logic [4*S-1:0] out_op;
  logic [5*S-1:0] out_rd, out_rs1, out_rs2;
  logic [2*S-1:0] out_tag;
  int checks = 0, failures = 0;
  bit done = 0;

  pair_fuser #(.SLOTS(S)) u_dut (.*);

  function automatic logic [31:0] ity(int f3, int rd, int rs, int imm);
    return {imm[11:0], rs[4:0], f3[2:0], rd[4:0], 7'h13};
  endfunction
  function automatic logic [31:0] rty(logic [6:0] opc, int f3, int rd, int a, int b, int f7 = 0);
    return {f7[6:0], b[4:0], a[4:0], f3[2:0], rd[4:0], opc};
  endfunction
  function automatic logic [31:0] SLLI(int rd, int rs, int sh); return ity(1, rd, rs, sh); endfunction
  function automatic logic [31:0] SRLI(int rd, int rs, int sh); return ity(5, rd, rs, sh); endfunction
  function automatic logic [31:0] ANDI(int rd, int rs, int im); return ity(7, rd, rs, im); endfunction
  function automatic logic [31:0] ADD(int rd, int a, int b); return rty(7'h33, 0, rd, a, b); endfunction
  function automatic logic [31:0] SUB(int rd, int a, int b); return rty(7'h33, 0, rd, a, b, 32); endfunction
  function automatic logic [31:0] OR(int rd, int a, int b); return rty(7'h33, 6, rd, a, b); endfunction
  function automatic logic [31:0] ADDW(int rd, int a, int b); return rty(7'h3b, 0, rd, a, b); endfunction

  // behavioural model: name each instruction, then look the pair up
  function automatic string kind(logic [31:0] x);
    if (x[6:0] == 7'h13 && x[14:12] == 1 && x[31:26] == 0) return "slli";
    if (x[6:0] == 7'h13 && x[14:12] == 5 && x[31:26] == 0) return "srli";
    if (x[6:0] == 7'h13 && x[14:12] == 7) return "andi";
    if (x[6:0] == 7'h33 && x[14:12] == 0 && x[31:25] == 0) return "add";
    if (x[6:0] == 7'h33 && x[14:12] == 6 && x[31:25] == 0) return "or";
    if (x[6:0] == 7'h3b && x[14:12] == 0 && x[31:25] == 0) return "addw";
    return "other";
  endfunction

  function automatic void model_pair(logic [31:0] a, logic [31:0] b, output int op, output int oth);
    string ka = kind(a), kb = kind(b);
    int d = a[11:7], ia = a[31:20], sa = a[25:20], sb = b[25:20];
    int r1 = b[19:15], r2 = b[24:20];
    bit two = (kb == "add" || kb == "addw" || kb == "or");
    bit uses = two ? ((r1 == d) ^ (r2 == d)) : (r1 == d);
    op = 0; oth = 0;
    if (d == 0 || b[11:7] != d || !uses) return;
    if (ka == "slli" && kb == "add" && sa >= 1 && sa <= 4) op = sa;
    else if (ka == "slli" && sa == 32 && kb == "srli" && sb == 31) op = 5;
    else if (ka == "slli" && sa == 32 && kb == "srli" && sb == 30) op = 6;
    else if (ka == "slli" && sa == 32 && kb == "srli" && sb == 29) op = 7;
    else if (ka == "srli" && kb == "add" && sa >= 29 && sa <= 32) op = sa - 21;
    else if (ka == "srli" && sa == 8 && kb == "andi" && b[31:20] == 12'h0ff) op = 12;
    else if (ka == "andi" && ia == 1 && kb == "add") op = 13;
    else if (ka == "andi" && ia == 1 && kb == "addw") op = 14;
    else if (ka == "andi" && ia == 12'hf00 && kb == "or") op = 15;
    if (op != 0 && two) oth = (r1 == d) ? r2 : r1;
  endfunction

  function automatic string req_of(int op);
    if (op == 0) return "R9/R12";
    if (op <= 4) return "R3";
    if (op <= 7) return "R4";
    if (op <= 11) return "R5";
    if (op == 12) return "R6";
    if (op <= 14) return "R7";
    return "R8";
  endfunction

  task automatic chk(bit ok, string req, int slot, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s slot %0d actual=%0d expected=%0d", req, slot, act, exp);
    end
  endtask

  task automatic compare();
    bit consumed = 0;
    for (int i = 0; i < S; i++) begin
      logic [31:0] a = in_instr[32*i +: 32];
      int op = 0, oth = 0;
      bit f;
      int e_rs2, e_tag;
      if (i + 1 < S) model_pair(a, in_instr[32*(i+1) +: 32], op, oth);
      f = !consumed && in_valid[i] && (i + 1 < S) && in_valid[(i+1) % S] && op != 0;
      chk(out_valid[i] == (in_valid[i] && !consumed), "R1", i, out_valid[i], in_valid[i] && !consumed);
      chk(out_fused[i] == f, "R2", i, out_fused[i], f);
      chk(out_op[4*i +: 4] == (f ? op : 0), f ? req_of(op) : "R12", i, out_op[4*i +: 4], f ? op : 0);
      e_rs2 = f ? oth : a[24:20];
      chk(out_rd[5*i +: 5] == a[11:7] && out_rs1[5*i +: 5] == a[19:15] && out_rs2[5*i +: 5] == e_rs2,
          "R10", i, out_rs2[5*i +: 5], e_rs2);
      e_tag = f ? {in_rvc[i], in_rvc[(i+1) % S]} : 0;
      chk(out_tag[2*i +: 2] == e_tag, "R11", i, out_tag[2*i +: 2], e_tag);
      consumed = f;
    end
  endtask

  task automatic apply(logic [31:0] i0, logic [31:0] i1, logic [31:0] i2, logic [31:0] i3,
                       logic [3:0] v = 4'hf, logic [3:0] c = 4'h0);
    @(posedge clk); #1;
    in_instr = {i3, i2, i1, i0}; in_valid = v; in_rvc = c;
    @(negedge clk);
    compare();
  endtask

  function automatic logic [31:0] rnd_instr();
    int sh[10] = '{1, 2, 3, 4, 5, 8, 29, 30, 31, 32};
    int im[4] = '{1, 255, 12'hf00, 2};
    int rd = $urandom_range(0, 3), a = $urandom_range(0, 3), b = $urandom_range(0, 3);
    case ($urandom_range(0, 7))
      0: return SLLI(rd, a, sh[$urandom_range(0, 9)]);
      1: return SRLI(rd, a, sh[$urandom_range(0, 9)]);
      2: return ANDI(rd, a, im[$urandom_range(0, 3)]);
      3: return ADD(rd, a, b);
      4: return ADDW(rd, a, b);
      5: return OR(rd, a, b);
      6: return SUB(rd, a, b);
      default: return SLLI(rd, a, 32);
    endcase
  endfunction

  initial begin
    in_valid = 0; in_instr = 0; in_rvc = 0;
    repeat (3) @(posedge clk);
    rst = 0;
    @(negedge clk);
    chk(out_valid == 0 && out_fused == 0, "R1", 0, out_valid, 0);   // idle state
    // R3 sh2add then R6 byte extract
    apply(SLLI(5, 6, 2), ADD(5, 5, 7), SRLI(8, 9, 8), ANDI(8, 8, 255));
    chk(out_op[3:0] == 2 && out_rs2[4:0] == 7, "R3", 0, out_op[3:0], 2);
    chk(out_op[11:8] == 12 && out_valid[3] == 0, "R6", 2, out_op[11:8], 12);
    // R4 + R2: slot1 consumed, cannot start sr31add with slot2
    apply(SLLI(1, 2, 32), SRLI(1, 1, 31), ADD(1, 1, 5), ADD(9, 9, 9));
    chk(out_op[3:0] == 5 && out_valid[2] && !out_fused[1], "R2", 1, out_fused[1], 0);
    apply(SLLI(1, 2, 32), SRLI(1, 1, 29), SRLI(3, 4, 32), ADD(3, 6, 3));
    chk(out_op[3:0] == 7 && out_op[11:8] == 11 && out_rs2[14:10] == 6, "R5", 2, out_op[11:8], 11);
    // R7 / R8 / R11 with compressed flags
    apply(ANDI(4, 2, 1), ADDW(4, 4, 3), ANDI(7, 2, -256), OR(7, 1, 7), 4'hf, 4'b0101);
    chk(out_op[3:0] == 14 && out_tag[1:0] == 2'b10, "R11", 0, out_tag[1:0], 2);
    chk(out_op[11:8] == 15 && out_rs2[14:10] == 1, "R8", 2, out_op[11:8], 15);
    apply(ANDI(4, 2, 1), ADD(4, 3, 4), SLLI(6, 6, 4), ADD(6, 6, 2));
    chk(out_op[3:0] == 13 && out_op[11:8] == 4, "R7", 0, out_op[3:0], 13);
    // R9 near misses
    apply(SLLI(5, 6, 5), ADD(5, 5, 7), SLLI(5, 6, 2), ADD(7, 5, 8));
    chk(out_fused == 0, "R9", 0, out_fused, 0);
    apply(SLLI(0, 6, 2), ADD(0, 0, 7), SLLI(5, 6, 2), ADD(5, 5, 5));
    chk(out_fused == 0, "R9", 2, out_fused, 0);
    apply(SRLI(8, 9, 8), ANDI(8, 8, 254), SRLI(3, 3, 28), ADD(3, 3, 1));
    chk(out_fused == 0, "R9", 0, out_fused, 0);
    // R2: invalid younger slot blocks fusion; last slot never starts
    apply(SLLI(5, 6, 1), ADD(5, 5, 7), ADD(1, 1, 2), SLLI(2, 3, 1), 4'b1101);
    chk(out_fused == 0 && out_valid == 4'b1101, "R2", 0, out_valid, 4'b1101);
    for (int n = 0; n < 4000; n++)
      apply(rnd_instr(), rnd_instr(), rnd_instr(), rnd_instr(), 4'($urandom), 4'($urandom));
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule